// File: doc/BRIEF.md
# Embedded-Sync Video Byte Stream Decoder

This block takes a single 8-bit component video byte stream in which line and frame timing travel inside the data, not on separate strobe wires. It sees each byte on the rising clock edge and watches for the four-byte timing reference (an all-ones byte, two all-zeros bytes, then a status byte). From the status byte it recovers the field, vertical-blanking and horizontal (start or end of active video) flags.

Between a start-of-active-video reference and the end of that run, the block splits the multiplexed chroma/luma bytes into separate Cb, Y and Cr outputs. It pulses a pixel-valid strobe once for each luma sample, and only on lines outside vertical blanking. The stream is assumed clean, so the protection bits of the status byte are neither checked nor corrected. A slave-mode enable input turns the whole decoder on or off.

Top module: `embsync_decoder`

## Requirements
- R1: While reset is asserted, pix_valid, cb_out, y_out, cr_out, h_flag, v_flag and field_flag are all 0.
- R2: When the enabled decoder samples the bytes FF, 00, 00, XY on consecutive edges, then after the edge that samples XY, field_flag = XY[6], v_flag = XY[5] and h_flag = XY[4]. H = 1 marks end of active video and H = 0 marks start.
- R3: Active bytes arrive in the order Cb0, Y0, Cr0, Y1. After the edge that samples Cr0, pix_valid is 1 with (Cb0, Y0, Cr0) on the outputs. After the edge that samples Y1, pix_valid is 1 with (Cb0, Y1, Cr0). After the edges that sample Cb0 and Y0, pix_valid is 0.
- R4: A start reference with V = 1 produces no pix_valid pulse for any byte that follows it.
- R5: Every start reference resets the byte phase to Cb, even when the previous run ended partway through a group.
- R6: A sampled FF byte ends the active run, so pix_valid is 0 after it and after the rest of the reference that follows.
- R7: While slave_en is 0, pix_valid is 0 and the flags keep their values. Bytes sampled then are discarded: a reference that starts while the block is disabled and ends after it is enabled is not decoded, and an active run open at disable time is closed.
- R8: XY[7] and XY[3:0] are ignored. The flags come from XY[6:4] whatever those bits hold.
- R9: field_flag follows the F bit of each decoded reference, so it changes in step with the fields of the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_en | input | 1 | Decoder enable (embedded-sync slave mode) |
| din | input | 8 | Incoming video byte |
| pix_valid | output | 1 | One pulse per decoded luma sample |
| cb_out | output | 8 | Blue-difference chroma of the current pixel |
| y_out | output | 8 | Luma of the current pixel |
| cr_out | output | 8 | Red-difference chroma of the current pixel |
| h_flag | output | 1 | H bit of the last reference (1 = end of active) |
| v_flag | output | 1 | V bit of the last reference (1 = blanking) |
| field_flag | output | 1 | F bit of the last reference |

## Verification
Every output is registered once from the sampled byte. The flags are therefore due one cycle after the status byte is sampled, and each pixel pulse one cycle after its Cr or second Y byte. The bench drives one byte per falling edge and checks the outputs at the next falling edge, which comes just after the rising edge that took that byte in. The bench sweeps all eight F/V/H combinations with varied protection bits. It runs whole lines with computed sample values, blanking lines, a truncated line, and enable changes placed inside a reference and inside an active run.

// File: rtl/embsync_decoder.sv
module embsync_decoder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slave_en,
  input  logic [W-1:0] din,
  output logic         pix_valid,
  output logic [W-1:0] cb_out,
  output logic [W-1:0] y_out,
  output logic [W-1:0] cr_out,
  output logic         h_flag,
  output logic         v_flag,
  output logic         field_flag
);
  localparam logic [W-1:0] KHI = '1;
  localparam logic [W-1:0] KLO = '0;
  localparam int FB = W - 2;
  localparam int VB = W - 3;
  localparam int HB = W - 4;

  logic [W-1:0] b2, b1, b0, cb_hold, y_hold;
  logic         active;
  logic [1:0]   phase;

  wire code_hit = slave_en && (b2 == KHI) && (b1 == KLO) && (b0 == KLO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b2 <= '0; b1 <= '0; b0 <= '0;
      cb_hold <= '0; y_hold <= '0;
      cb_out <= '0; y_out <= '0; cr_out <= '0;
      pix_valid <= 1'b0; active <= 1'b0; phase <= 2'd0;
      h_flag <= 1'b0; v_flag <= 1'b0; field_flag <= 1'b0;
    end else if (!slave_en) begin
      b2 <= '0; b1 <= '0; b0 <= '0;
      active <= 1'b0;
      pix_valid <= 1'b0;
    end else begin
      b2 <= b1; b1 <= b0; b0 <= din;
      pix_valid <= 1'b0;
      if (code_hit) begin
        field_flag <= din[FB];
        v_flag     <= din[VB];
        h_flag     <= din[HB];
        active     <= !din[HB] && !din[VB];
        phase      <= 2'd0;
      end else if (din == KHI) begin
        active <= 1'b0;
      end else if (active) begin
        phase <= phase + 2'd1;
        case (phase)
          2'd0: cb_hold <= din;
          2'd1: y_hold  <= din;
          2'd2: begin
            cb_out <= cb_hold; y_out <= y_hold; cr_out <= din;
            pix_valid <= 1'b1;
          end
          default: begin
            y_out <= din;
            pix_valid <= 1'b1;
          end
        endcase
      end
    end
  end

  p_flags_follow_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    code_hit |=> (field_flag == $past(din[FB])) && (v_flag == $past(din[VB]))
                 && (h_flag == $past(din[HB])));

  p_cbycry_pairs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && $past(pix_valid)) |=> !pix_valid);

  p_blank_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> !v_flag);

  p_ff_ends_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_en && din == KHI) |=> !pix_valid);

  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_en |=> (!pix_valid && $stable(field_flag) && $stable(v_flag) && $stable(h_flag)));
endmodule

// File: tb/embsync_decoder_tb.sv
module embsync_decoder_tb;
  logic clk = 1'b0, rst_n = 1'b0, slave_en = 1'b0;
  logic [7:0] din = 8'h00;
  logic pix_valid, h_flag, v_flag, field_flag;
  logic [7:0] cb_out, y_out, cr_out;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  embsync_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .din(din),
    .pix_valid(pix_valid), .cb_out(cb_out), .y_out(y_out), .cr_out(cr_out),
    .h_flag(h_flag), .v_flag(v_flag), .field_flag(field_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    din = b;
    @(negedge clk);
  endtask

  function automatic logic [7:0] pval(input int k);
    return 8'(16 + (k * 37) % 200);
  endfunction

  task automatic code(input bit f, input bit v, input bit h, input logic [7:0] junk);
    send(8'hFF); chk("R6 ff", int'(pix_valid), 0);
    send(8'h00); send(8'h00);
    send({junk[7], f, v, h, junk[3:0]});
    chk("R2/R8/R9 field", int'(field_flag), int'(f));
    chk("R2/R8 v", int'(v_flag), int'(v));
    chk("R2/R8 h", int'(h_flag), int'(h));
    chk("R6 code", int'(pix_valid), 0);
  endtask

  task automatic run_line(input bit f, input bit v, input int groups, input int base);
    code(f, v, 1'b0, 8'h80);
    for (int g = 0; g < groups; g++) begin
      int k = base + 4 * g;
      send(pval(k));     chk("R3 cb slot", int'(pix_valid), 0);
      send(pval(k + 1)); chk("R3 y0 slot", int'(pix_valid), 0);
      send(pval(k + 2)); chk("R3/R4 cr slot", int'(pix_valid), int'(!v));
      if (!v) begin
        chk("R3 cb0", int'(cb_out), int'(pval(k)));
        chk("R3 y0", int'(y_out), int'(pval(k + 1)));
        chk("R3 cr0", int'(cr_out), int'(pval(k + 2)));
      end
      send(pval(k + 3)); chk("R3/R4 y1 slot", int'(pix_valid), int'(!v));
      if (!v) begin
        chk("R3 cb1", int'(cb_out), int'(pval(k)));
        chk("R3 y1", int'(y_out), int'(pval(k + 3)));
        chk("R3 cr1", int'(cr_out), int'(pval(k + 2)));
      end
    end
    code(f, v, 1'b1, 8'h80);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pv", int'(pix_valid), 0);
    chk("R1 cb", int'(cb_out), 0);
    chk("R1 y", int'(y_out), 0);
    chk("R1 cr", int'(cr_out), 0);
    chk("R1 flags", int'({h_flag, v_flag, field_flag}), 0);
    rst_n = 1'b1;
    slave_en = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) code(i[2], i[1], i[0], 8'(i * 29 + 7));

    run_line(1'b0, 1'b0, 6, 0);
    run_line(1'b1, 1'b0, 3, 100);
    run_line(1'b1, 1'b1, 2, 200);
    run_line(1'b0, 1'b0, 1, 50);

    // R5: truncated run, then a fresh line must restart at Cb
    code(1'b0, 1'b0, 1'b0, 8'h80);
    send(pval(400)); send(pval(401)); send(pval(402));
    chk("R5 partial cr", int'(pix_valid), 1);
    code(1'b0, 1'b0, 1'b1, 8'h80);
    run_line(1'b0, 1'b0, 2, 300);

    // R7: a reference sent while disabled is discarded
    slave_en = 1'b0;
    send(8'hFF); send(8'h00); send(8'h00); send(8'hC0);
    chk("R7 field held", int'(field_flag), 0);
    chk("R7 h held", int'(h_flag), 1);
    send(pval(1)); send(pval(2)); send(pval(3));
    chk("R7 no pv", int'(pix_valid), 0);

    // R7: disabling inside an active run closes it
    slave_en = 1'b1;
    code(1'b0, 1'b0, 1'b0, 8'h80);
    send(pval(10)); send(pval(11));
    slave_en = 1'b0;
    send(pval(12)); chk("R7 off mid run", int'(pix_valid), 0);
    slave_en = 1'b1;
    send(pval(13)); send(pval(14));
    send(pval(15)); chk("R7 run closed", int'(pix_valid), 0);
    send(pval(16)); chk("R7 run closed 2", int'(pix_valid), 0);

    // R7: reference spanning the enable edge is not decoded
    slave_en = 1'b0;
    send(8'hFF); send(8'h00);
    slave_en = 1'b1;
    send(8'h00); send(8'hF0);
    chk("R7 span field", int'(field_flag), 0);
    chk("R7 span v", int'(v_flag), 0);
    chk("R7 span h", int'(h_flag), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule